// File: doc/BRIEF.md
# Entropy Conditioning CRC Register

This block turns the single-bit outputs of three free-running noise sources into a 64-bit random word. On every clock it XORs together the bits of the sources that are currently enabled and shifts the result into a 64-bit CRC register. The whole CRC state is presented as a read-only data word.

A control word sets the following:
- which sources take part;
- an oscillator-tuning value for one noise cell at a time;
- whether reads are rate-limited;
- the minimum number of accumulation cycles between two reads.

Software configures the block with four control writes in sequence. Each of the first three enables a single source and carries that cell's tuning value. The last write turns on all the wanted sources and sets the final mode and wait count.

A consumer raises `rd_req` and takes `rd_data` in the cycle where `rd_ready` is high. When rate limiting is on, `rd_ready` stays low until the wait count has elapsed since the last completed read. This gives the CRC time to absorb fresh noise.

Top module: `entropy_crc_conditioner`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the CRC state to 0, disables all sources, clears all tuning values, the mode bit, the wait count and the accumulation count, so `rd_ready` is 1 after reset.
- R2: At each clock edge out of reset the CRC state S becomes (S << 1) XOR (P if (b XOR S[63]) else 0). Here b is the conditioned input bit and P = 64'h231DCEE91262B8A3, the low 64 bits of x^64+x^61+x^57+x^56+x^52+x^51+x^50+x^48+x^47+x^46+x^43+x^42+x^41+x^39+x^38+x^37+x^35+x^32+x^28+x^25+x^22+x^21+x^17+x^15+x^13+x^12+x^11+x^7+x^5+x+1.
- R3: The conditioned bit b is the XOR of `noise_i[i]` over the sources whose enable bit `ctl_wdata[i]` (bits [2:0]) was last written as 1. Disabled sources have no effect on the CRC.
- R4: With all three enables clear, b is 0, so a zero CRC state stays zero whatever the noise inputs do.
- R5: With the mode bit (`ctl_wdata[5]`) set, `rd_ready` is low until the accumulation count reaches the wait field (`ctl_wdata[21:6]`). The count advances by one per clock while it is below the wait value.
- R6: A completed read (`rd_req` and `rd_ready` high at a clock edge) restarts the accumulation count at 0, so with the mode bit set and a nonzero wait, `rd_ready` is low in the next cycle.
- R7: With the mode bit clear, `rd_ready` is always 1.
- R8: A control write with exactly one enable bit i set loads the tuning field `ctl_wdata[4:3]` into `vco_o[2*i+1:2*i]`. A control write with zero or several enable bits set leaves all tuning values unchanged.
- R9: A control write takes effect at its clock edge. The CRC update at that same edge uses the previous enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| noise_i | input | 3 | One raw noise bit per source |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 22 | Control word: [2:0] enables, [4:3] tuning, [5] mode, [21:6] wait |
| rd_req | input | 1 | Read request |
| rd_ready | output | 1 | Read may complete this cycle |
| rd_data | output | 64 | CRC state, read-only |
| vco_o | output | 6 | Tuning value per noise cell, 2 bits each |

## Verification
The assertions take for granted that the noise bits and the control word are already synchronous to `clk` and stable around each edge. The bench keeps to this by changing every input only on the falling edge. The rate-limit property assumes no control write lands in the same cycle as a completed read, because a write can change the mode. The bench never overlaps the two. The zero-stays-zero property relies on reset having cleared the state, and the bench always starts with reset held across the first edge.

// File: rtl/entropy_crc_conditioner.sv
module entropy_crc_conditioner #(
  parameter int N_SRC = 3,
  parameter int VCO_W = 2,
  parameter int WAIT_W = 16,
  parameter int W = 64,
  parameter logic [63:0] POLY = 64'h231D_CEE9_1262_B8A3,
  localparam int CTL_W = N_SRC + VCO_W + 1 + WAIT_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       noise_i,
  input  logic                   ctl_we,
  input  logic [CTL_W-1:0]       ctl_wdata,
  input  logic                   rd_req,
  output logic                   rd_ready,
  output logic [W-1:0]           rd_data,
  output logic [N_SRC*VCO_W-1:0] vco_o
);
  localparam int VCO_LSB  = N_SRC;
  localparam int MODE_BIT = N_SRC + VCO_W;
  localparam int WAIT_LSB = MODE_BIT + 1;

  logic [N_SRC-1:0]  en_q;
  logic              mode_q;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] cnt_q;
  logic [W-1:0]      crc_q;
  logic              cond_bit;
  logic              fb;
  logic              rd_fire;
  logic              one_src;

  assign cond_bit = ^(noise_i & en_q);
  assign fb       = cond_bit ^ crc_q[W-1];
  assign rd_data  = crc_q;
  assign rd_ready = !mode_q || (cnt_q >= wait_q);
  assign rd_fire  = rd_req && rd_ready;
  assign one_src  = $onehot(ctl_wdata[N_SRC-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q  <= '0;
      en_q   <= '0;
      mode_q <= 1'b0;
      wait_q <= '0;
      cnt_q  <= '0;
    end else begin
      crc_q <= {crc_q[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
      if (ctl_we) begin
        en_q   <= ctl_wdata[N_SRC-1:0];
        mode_q <= ctl_wdata[MODE_BIT];
        wait_q <= ctl_wdata[WAIT_LSB +: WAIT_W];
      end
      if (rd_fire)
        cnt_q <= '0;
      else if (cnt_q < wait_q)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_cell
    logic [VCO_W-1:0] vco_q;
    always_ff @(posedge clk) begin
      if (rst)
        vco_q <= '0;
      else if (ctl_we && one_src && ctl_wdata[i])
        vco_q <= ctl_wdata[VCO_LSB +: VCO_W];
    end
    assign vco_o[i*VCO_W +: VCO_W] = vco_q;
  end
endmodule

module entropy_crc_conditioner_chk #(
  parameter int N_SRC = 3,
  parameter int VCO_W = 2,
  parameter int WAIT_W = 16,
  parameter int W = 64,
  parameter logic [63:0] POLY = 64'h231D_CEE9_1262_B8A3,
  localparam int CTL_W = N_SRC + VCO_W + 1 + WAIT_W
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ctl_we,
  input logic [CTL_W-1:0]       ctl_wdata,
  input logic                   rd_req,
  input logic                   rd_ready,
  input logic [W-1:0]           rd_data,
  input logic [N_SRC*VCO_W-1:0] vco_o,
  input logic [N_SRC-1:0]       en_q,
  input logic                   mode_q,
  input logic [WAIT_W-1:0]      wait_q
);
  localparam int MODE_BIT = N_SRC + VCO_W;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && vco_o == '0 && rd_ready));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    en_q == '0 |=> rd_data == ({$past(rd_data[W-2:0]), 1'b0} ^
                               ($past(rd_data[W-1]) ? POLY[W-1:0] : '0)));

  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0 && rd_data == '0) |=> rd_data == '0);

  // R6
  read_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ready && mode_q && wait_q != '0 && !ctl_we) |=> !rd_ready);

  // R7
  free_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !ctl_wdata[MODE_BIT]) |=> rd_ready);

  // R8
  vco_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && $countones(ctl_wdata[N_SRC-1:0]) != 1) |=> $stable(vco_o));
endmodule

bind entropy_crc_conditioner entropy_crc_conditioner_chk #(
  .N_SRC(N_SRC), .VCO_W(VCO_W), .WAIT_W(WAIT_W), .W(W), .POLY(POLY)
) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .rd_req(rd_req), .rd_ready(rd_ready), .rd_data(rd_data), .vco_o(vco_o),
  .en_q(en_q), .mode_q(mode_q), .wait_q(wait_q)
);

// File: tb/sim_entropy_crc_conditioner.sv
module sim_entropy_crc_conditioner;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  noise_i = '0;
  logic        ctl_we = 1'b0;
  logic [21:0] ctl_wdata = '0;
  logic        rd_req = 1'b0;
  logic        rd_ready;
  logic [63:0] rd_data;
  logic [5:0]  vco_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  entropy_crc_conditioner u0 (
    .clk(clk), .rst(rst), .noise_i(noise_i), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .rd_req(rd_req), .rd_ready(rd_ready),
    .rd_data(rd_data), .vco_o(vco_o)
  );

  function automatic logic [63:0] mk_poly();
    int exps [30] = '{61,57,56,52,51,50,48,47,46,43,42,41,39,38,37,
                      35,32,28,25,22,21,17,15,13,12,11,7,5,1,0};
    logic [63:0] p = '0;
    foreach (exps[k]) p[exps[k]] = 1'b1;
    return p;
  endfunction
  localparam logic [63:0] P = mk_poly();

  // reference model: R2, R3, R9
  logic [63:0] m_crc;
  logic [2:0]  m_en;
  logic        m_b;
  always @(posedge clk) begin
    if (rst) begin
      m_crc <= '0;
      m_en  <= '0;
    end else begin
      m_b = ^(noise_i & m_en);
      m_crc <= {m_crc[62:0], 1'b0} ^ ((m_b ^ m_crc[63]) ? P : 64'd0);
      if (ctl_we) m_en <= ctl_wdata[2:0];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] en, input logic [1:0] vco, input logic mode, input logic [15:0] wt);
    ctl_wdata = {wt, mode, vco, en};
    ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  localparam logic [5:0] VEC [8] = '{
    {3'b001, 3'b001}, {3'b010, 3'b011}, {3'b100, 3'b111}, {3'b011, 3'b011},
    {3'b110, 3'b010}, {3'b111, 3'b101}, {3'b101, 3'b110}, {3'b001, 3'b110}
  };

  initial begin
    int k;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(rd_data == 64'd0, "R1 crc", rd_data, 64'd0);
    chk(rd_ready == 1'b1, "R1 ready", {63'd0, rd_ready}, 64'd1);
    chk(vco_o == 6'd0, "R1 vco", {58'd0, vco_o}, 64'd0);

    // R4: all enables clear, noise toggles, state stays zero
    for (int i = 0; i < 6; i++) begin noise_i = 3'(i); cyc(1); end
    chk(rd_data == 64'd0, "R4 zero hold", rd_data, 64'd0);

    // R9: write enabling source 0 while noise=1; that edge uses old enables
    noise_i = 3'b001;
    wr(3'b001, 2'd0, 1'b0, 16'd0);
    chk(rd_data == 64'd0, "R9 write edge", rd_data, 64'd0);
    cyc(1);
    chk(rd_data == P, "R2 first bit", rd_data, P);
    noise_i = 3'b000;
    cyc(1);
    chk(rd_data == 64'h463B_9DD2_24C5_7146, "R2 shift", rd_data, 64'h463B_9DD2_24C5_7146);

    // R2/R3 vector walk
    foreach (VEC[v]) begin
      noise_i = VEC[v][2:0];
      wr(VEC[v][5:3], 2'd0, 1'b0, 16'd0);
      for (int c = 0; c < 4; c++) begin noise_i = VEC[v][2:0] ^ 3'(c); cyc(1); end
      chk(rd_data == m_crc, "R3 vector", rd_data, m_crc);
    end
    noise_i = 3'b000;

    // R8 tuning values
    wr(3'b001, 2'd2, 1'b0, 16'd0);
    wr(3'b010, 2'd1, 1'b0, 16'd0);
    wr(3'b100, 2'd3, 1'b0, 16'd0);
    chk(vco_o == 6'b11_01_10, "R8 load", {58'd0, vco_o}, {58'd0, 6'b11_01_10});
    wr(3'b111, 2'd0, 1'b0, 16'd0);
    wr(3'b000, 2'd1, 1'b0, 16'd0);
    chk(vco_o == 6'b11_01_10, "R8 keep", {58'd0, vco_o}, {58'd0, 6'b11_01_10});

    // R5 interlock
    wr(3'b000, 2'd0, 1'b1, 16'd5);
    k = 0;
    while (!rd_ready && k < 50) begin k++; cyc(1); end
    chk(k == 5, "R5 wait", 64'(k), 64'd5);
    rd_req = 1'b1;
    cyc(1);
    chk(rd_ready == 1'b0, "R6 restart", {63'd0, rd_ready}, 64'd0);
    k = 0;
    while (!rd_ready && k < 50) begin k++; cyc(1); end
    chk(k == 5, "R5 early read stall", 64'(k), 64'd5);
    cyc(1);
    chk(rd_ready == 1'b0, "R6 second read", {63'd0, rd_ready}, 64'd0);
    rd_req = 1'b0;

    // R7 free mode
    wr(3'b000, 2'd0, 1'b0, 16'd5);
    rd_req = 1'b1;
    k = 0;
    for (int c = 0; c < 8; c++) begin if (rd_ready) k++; cyc(1); end
    chk(k == 8, "R7 never stalled", 64'(k), 64'd8);
    rd_req = 1'b0;
    chk(rd_data == m_crc, "R2 model end", rd_data, m_crc);

    // R1 reset mid-run
    noise_i = 3'b001;
    wr(3'b001, 2'd3, 1'b1, 16'd9);
    cyc(3);
    rst = 1'b1;
    cyc(1);
    rst = 1'b0;
    chk(rd_data == 64'd0, "R1 crc again", rd_data, 64'd0);
    chk(rd_ready == 1'b1, "R1 ready again", {63'd0, rd_ready}, 64'd1);
    chk(vco_o == 6'd0, "R1 vco again", {58'd0, vco_o}, 64'd0);
    cyc(3);
    chk(rd_data == 64'd0, "R1 sources off", rd_data, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule